// File: doc/BRIEF.md
# Truncating Multiplier with Exact Error Term

This block multiplies two single-precision binary floating-point operands under round-toward-zero and returns two words: the truncated product `p` and the residue `e`, where `e` is exactly the part of the true product that truncation threw away. Because truncation never rounds up, the discarded tail is a non-negative fraction of one unit in the last place of `p`. It always fits in a 24-bit significand. The pair therefore represents the product with no loss: `a*b = p + e` holds exactly. It gives the same result as a multiply followed by a fused multiply-add with `-p`, but here both words come from one full-width significand product.

The unit is used as a building block for extended-precision arithmetic on datapaths that only truncate. A request is offered with `in_valid` and accepted only while the unit is idle. The result appears with a one-cycle `out_valid` pulse and stays on the outputs until the next result replaces it. The number model is restricted. An exponent field of zero means zero, and subnormals are not produced. Tiny results flush to zero and overflow saturates. Infinities, NaNs and exception flags are not handled.

Control is a three-state machine. `ST_IDLE` waits. Transition T_ACCEPT goes from `ST_IDLE` to `ST_MUL` when `in_valid` is high, and captures the operands. `ST_MUL` forms and normalizes the significand product and the result exponent. Transition T_STEP then goes from `ST_MUL` to `ST_PACK` without condition. `ST_PACK` encodes `p` and `e`. Transition T_EMIT goes from `ST_PACK` back to `ST_IDLE`, registers both words and raises `out_valid`.

Top module: `trunc_mul_eft`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request yet, `out_valid` is 0 and `p_out` and `e_out` are all zeros.
- R2: A request accepted at clock edge N gives `out_valid` = 1 only in the cycle after edge N+2, for exactly one cycle.
- R3: `in_valid` is ignored while the machine is in `ST_MUL` or `ST_PACK`. No extra result is produced, and the pending result is not changed.
- R4: `p_out` is encoded as sign in bit 31, biased exponent in bits 30..23 (bias 127) and fraction in bits 22..0. The sign is the XOR of the operand sign bits. The significand is the leading 24 bits of the exact 48-bit significand product. The exponent is ea+eb-127, plus 1 when product bit 47 is set.
- R5: `e_out` holds the dropped product bits, normalized, in the same encoding, with the same sign as `p_out`. Its exponent is p's exponent minus 24 minus the leading-zero count of the 24-bit dropped field. When the dropped bits are all zero, `e_out` is 32'h00000000.
- R6: When `p_out` is neither zero nor saturated and `e_out` is not flushed, `a*b = p + e` holds exactly.
- R7: An operand with exponent field 0 is zero. Both outputs are then 32'h00000000.
- R8: If p's exponent would be 255 or more, `p_out` saturates to sign, exponent 8'hFE and an all-ones fraction, and `e_out` is 32'h00000000.
- R9: If p's exponent would be 0 or less, both outputs are 32'h00000000.
- R10: If `p_out` is normal but e's exponent would be 0 or less, `e_out` is 32'h00000000.
- R11: Between two `out_valid` pulses, `p_out` and `e_out` do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe, taken only in ST_IDLE |
| a_in | input | 32 | First operand, binary32 |
| b_in | input | 32 | Second operand, binary32 |
| out_valid | output | 1 | One-cycle result strobe |
| p_out | output | 32 | Truncated product |
| e_out | output | 32 | Exact truncation residue |

## Verification
The bench builds the unit with its default exponent width of 8 and fraction width of 23, which is the single-precision format. With these values, exponent sums that saturate or flush to zero are reached easily. Fully random exponents cover both ends, and a middle exponent band covers the exact identity. All-ones fractions force the longest dropped tails. Operands near the bottom of the range push the residue exponent below one while the product itself stays normal.

// File: rtl/tzm_pkg.sv
package tzm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MUL  = 2'd1,
        ST_PACK = 2'd2
    } tzm_state_e;

endpackage

// File: rtl/tzm_lzc.sv
module tzm_lzc #(
    parameter int W = 24,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  d,
    output logic [CW-1:0] cnt
);

    // Scan upward; the highest set bit writes last and wins.
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (d[i]) cnt = CW'(W - 1 - i);
        end
    end

endmodule

// File: rtl/tzm_sig_mul.sv
module tzm_sig_mul #(
    parameter int FRAC_W = 23,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int PROD_W = 2 * SIG_W
) (
    input  logic [FRAC_W-1:0] frac_a,
    input  logic [FRAC_W-1:0] frac_b,
    output logic [PROD_W-1:0] prod
);

    logic [PROD_W-1:0] sig_a;
    logic [PROD_W-1:0] sig_b;

    assign sig_a = PROD_W'({1'b1, frac_a});
    assign sig_b = PROD_W'({1'b1, frac_b});
    assign prod  = sig_a * sig_b;

endmodule

// File: rtl/tzm_pack.sv
module tzm_pack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int PROD_W = 2 * SIG_W,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int XW     = EXP_W + 3,
    localparam int EMAX   = (1 << EXP_W) - 1,
    localparam int CW     = $clog2(SIG_W + 1)
) (
    input  logic                 sign,
    input  logic                 zero,
    input  logic signed [XW-1:0] ep,
    input  logic [PROD_W-2:0]    norm_low,
    output logic [WORD_W-1:0]    p_word,
    output logic [WORD_W-1:0]    e_word
);

    logic [FRAC_W-1:0]    p_frac;
    logic [SIG_W-1:0]     drop;
    logic [CW-1:0]        lz;
    logic [FRAC_W-1:0]    e_frac;
    logic signed [XW-1:0] ee;

    assign p_frac = norm_low[PROD_W-2:SIG_W];
    assign drop   = norm_low[SIG_W-1:0];

    tzm_lzc #(.W(SIG_W)) lzc_i (
        .d   (drop),
        .cnt (lz)
    );

    assign e_frac = FRAC_W'(drop << lz);
    assign ee     = ep - XW'(SIG_W) - XW'(lz);

    always_comb begin
        p_word = '0;
        e_word = '0;
        if (zero || ep <= 0) begin
            p_word = '0;
        end else if (ep >= EMAX) begin
            p_word = {sign, EXP_W'(EMAX - 1), {FRAC_W{1'b1}}};
        end else begin
            p_word = {sign, ep[EXP_W-1:0], p_frac};
            if (drop != '0 && ee > 0) begin
                e_word = {sign, ee[EXP_W-1:0], e_frac};
            end
        end
    end

endmodule

// File: rtl/trunc_mul_eft.sv
module trunc_mul_eft
    import tzm_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1,
    localparam int PROD_W = 2 * SIG_W,
    localparam int XW     = EXP_W + 3,
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] b_in,
    output logic              out_valid,
    output logic [WORD_W-1:0] p_out,
    output logic [WORD_W-1:0] e_out
);

    tzm_state_e state_q, state_d;

    logic [WORD_W-1:0]    op_a, op_b;
    logic [PROD_W-1:0]    prod;
    logic [PROD_W-2:0]    norm_d, norm_q;
    logic signed [XW-1:0] ep_d, ep_q;
    logic signed [XW-1:0] ea_x, eb_x;
    logic                 sign_q, zero_q;
    logic [WORD_W-1:0]    p_w, e_w;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions T_ACCEPT, T_STEP, T_EMIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = ST_MUL;
            ST_MUL:  state_d = ST_PACK;
            ST_PACK: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    tzm_sig_mul #(.FRAC_W(FRAC_W)) mul_i (
        .frac_a (op_a[FRAC_W-1:0]),
        .frac_b (op_b[FRAC_W-1:0]),
        .prod   (prod)
    );

    assign ea_x   = XW'(op_a[WORD_W-2:FRAC_W]);
    assign eb_x   = XW'(op_b[WORD_W-2:FRAC_W]);
    assign norm_d = prod[PROD_W-1] ? prod[PROD_W-2:0]
                                   : {prod[PROD_W-3:0], 1'b0};
    assign ep_d   = ea_x + eb_x - XW'(BIAS) + XW'(prod[PROD_W-1]);

    // Datapath registers advanced by the state machine
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_a   <= '0;
            op_b   <= '0;
            norm_q <= '0;
            ep_q   <= '0;
            sign_q <= 1'b0;
            zero_q <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: if (in_valid) begin
                    op_a <= a_in;
                    op_b <= b_in;
                end
                ST_MUL: begin
                    norm_q <= norm_d;
                    ep_q   <= ep_d;
                    sign_q <= op_a[WORD_W-1] ^ op_b[WORD_W-1];
                    zero_q <= (op_a[WORD_W-2:FRAC_W] == '0) ||
                              (op_b[WORD_W-2:FRAC_W] == '0);
                end
                ST_PACK: ;
                default: ;
            endcase
        end
    end

    tzm_pack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) pack_i (
        .sign     (sign_q),
        .zero     (zero_q),
        .ep       (ep_q),
        .norm_low (norm_q),
        .p_word   (p_w),
        .e_word   (e_w)
    );

    // Output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            p_out     <= '0;
            e_out     <= '0;
        end else begin
            out_valid <= (state_q == ST_PACK);
            if (state_q == ST_PACK) begin
                p_out <= p_w;
                e_out <= e_w;
            end
        end
    end

endmodule

// File: rtl/tzm_checker.sv
module tzm_checker #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              out_valid,
    input logic [WORD_W-1:0] p_out,
    input logic [WORD_W-1:0] e_out
);

    // R2: result strobe lasts a single cycle
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R2: a result is always preceded by a request three edges earlier
    a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3));

    // R11: outputs hold between pulses
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(p_out) && $stable(e_out)));

    // R5: a nonzero residue carries the product sign
    a_r5_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && e_out != '0) |-> (e_out[WORD_W-1] == p_out[WORD_W-1]));

    // R5: residue lies below one unit in the last place of p
    a_r5_below_ulp: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && e_out != '0) |->
        ({2'b00, e_out[WORD_W-2:FRAC_W]} + (EXP_W+2)'(FRAC_W + 1) <=
         {2'b00, p_out[WORD_W-2:FRAC_W]}));

    // R8: the all-ones exponent is never produced
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (p_out[WORD_W-2:FRAC_W] != '1));

endmodule

bind trunc_mul_eft tzm_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .p_out     (p_out),
    .e_out     (e_out)
);

// File: tb/trunc_mul_eft_tb_top.sv
module trunc_mul_eft_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] a_in = '0;
    logic [31:0] b_in = '0;
    logic        out_valid;
    logic [31:0] p_out, e_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    trunc_mul_eft dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_in(a_in), .b_in(b_in),
        .out_valid(out_valid), .p_out(p_out), .e_out(e_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp_v);
        end
    endtask

    // Reference: truncated product and residue from the exact integer product
    function automatic void model(input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] xp, output logic [31:0] xe,
                                  output bit exact);
        int ea = int'(a[30:23]);
        int eb = int'(b[30:23]);
        logic s = a[31] ^ b[31];
        logic [63:0] v, pm, rem, em;
        int k, j, ep, ee;
        xp = '0; xe = '0; exact = 0;
        if (ea == 0 || eb == 0) return;
        v = {40'd0, 1'b1, a[22:0]} * {40'd0, 1'b1, b[22:0]};
        k = v[47] ? 47 : 46;
        ep = ea + eb - 127 + (k - 46);
        if (ep <= 0) return;
        if (ep >= 255) begin
            xp = {s, 8'hFE, 23'h7FFFFF};
            return;
        end
        pm  = v >> (k - 23);
        rem = v - (pm << (k - 23));
        xp  = {s, 8'(ep), pm[22:0]};
        exact = 1;
        if (rem == 0) return;
        j = 0;
        for (int i = 0; i < 48; i++) if (rem[i]) j = i;
        ee = ep - (k - j);
        if (ee <= 0) begin
            exact = 0;
            return;
        end
        em = rem << (23 - j);
        xe = {s, 8'(ee), em[22:0]};
    endfunction

    // Scaled integer identity: a*b == p + e
    function automatic bit identity(input logic [31:0] a, input logic [31:0] b,
                                    input logic [31:0] p, input logic [31:0] e);
        int ea = int'(a[30:23]);
        int eb = int'(b[30:23]);
        logic [127:0] lhs, rhs, mp, me;
        lhs = ({104'd0, 1'b1, a[22:0]} * {104'd0, 1'b1, b[22:0]}) << 30;
        mp  = {104'd0, 1'b1, p[22:0]};
        rhs = mp << (int'(p[30:23]) + 180 - ea - eb);
        if (e != 0) begin
            if (e[31] != p[31]) return 0;
            me  = {104'd0, 1'b1, e[22:0]};
            rhs = rhs + (me << (int'(e[30:23]) + 180 - ea - eb));
        end
        return (lhs == rhs) && (p[31] == (a[31] ^ b[31]));
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input string req);
        logic [31:0] xp, xe;
        bit exact;
        model(a, b, xp, xe, exact);
        @(negedge clk);
        a_in = a; b_in = b; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R2 no early strobe", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        check("R2 strobe", {31'd0, out_valid}, 32'd1);
        check({req, " R4 p"}, p_out, xp);
        check({req, " R5 e"}, e_out, xe);
        if (exact) check({req, " R6 identity"}, {31'd0, identity(a, b, p_out, e_out)}, 32'd1);
    endtask

    logic [31:0] ra, rb;

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        check("R1 reset p", p_out, 32'd0);
        check("R1 reset e", e_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle valid", {31'd0, out_valid}, 32'd0);
        check("R1 idle e", e_out, 32'd0);

        // Directed corners
        run_op(32'h3F800000, 32'h3F800000, "R5 zero tail");
        run_op(32'h3FFFFFFF, 32'h3FFFFFFF, "R4 all-ones");
        run_op(32'hBFFFFFFF, 32'h40FFFFFF, "R4 sign");
        run_op(32'hC0400001, 32'hC0A00003, "R6 neg-neg");
        run_op(32'h00000000, 32'h40400000, "R7 zero a");
        run_op(32'hBF800000, 32'h00123456, "R7 zero b");
        run_op(32'h7F000000, 32'h7F000000, "R8 overflow");
        run_op(32'hFF7FFFFF, 32'h3FFFFFFF, "R8 overflow neg");
        run_op(32'h00800000, 32'h00800000, "R9 tiny");
        run_op(32'h05FFFFFF, 32'h3FFFFFFF, "R10 e flush");
        run_op(32'h0B7FFFFF, 32'h3FFFFFFF, "R10 e low");

        // R3: requests while busy are ignored
        begin
            logic [31:0] xp, xe;
            bit exact;
            model(32'h3FC00001, 32'h40200007, xp, xe, exact);
            @(negedge clk);
            a_in = 32'h3FC00001; b_in = 32'h40200007; in_valid = 1'b1;
            @(negedge clk);
            a_in = 32'h7F000000; b_in = 32'h7F000000;
            @(negedge clk);
            @(negedge clk);
            in_valid = 1'b0;
            check("R3 strobe", {31'd0, out_valid}, 32'd1);
            check("R3 p kept", p_out, xp);
            check("R3 e kept", e_out, xe);
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                check("R3 no extra strobe", {31'd0, out_valid}, 32'd0);
                check("R11 hold p", p_out, xp);
            end
        end

        // Random: middle exponent band, then full range
        for (int i = 0; i < 300; i++) begin
            ra = $urandom;
            rb = $urandom;
            ra[30:23] = 8'(64 + ($urandom % 128));
            rb[30:23] = 8'(64 + ($urandom % 128));
            if (i % 10 == 0) begin
                ra[22:0] = '1;
                rb[22:0] = '1;
            end
            run_op(ra, rb, "R6 random mid");
        end
        for (int i = 0; i < 300; i++) begin
            ra = $urandom;
            rb = $urandom;
            ra[30:23] = 8'($urandom % 255);
            rb[30:23] = 8'($urandom % 255);
            run_op(ra, rb, "R4 random full");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R2: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule